// File: doc/BRIEF.md
# Octal Divide-by-Two Clock Driver

This block turns one input clock into eight copies of a half-rate clock. A single stored toggle bit inverts on every rising clock edge. Six outputs carry that bit and two carry its complement, so the two groups always stand in opposite phase. Two active-low override inputs take the outputs to fixed levels at once, with no clock edge needed. One forces the in-phase group high. The other forces it low. The inverted group always takes the opposite level to the in-phase group, except when both overrides are low together: then all eight outputs go low.

The override decode is combinational, so an override shows at the outputs as soon as it is applied. The stored bit is loaded asynchronously when an override falls. While an override is held, the stored bit is also reloaded from the override levels on each rising clock edge. As a result, the outputs after release continue from the level the outputs showed last. If both overrides are held and then released together, the stored bit reads low.

Top module: `div2_octal_driver`

## Requirements
- R1: While both overrides are high, every rising clock edge inverts all eight outputs, so each output runs at half the clock rate.
- R2: Bits 5:0 of `q` always hold one common value, and bits 7:6 always hold one common value.
- R3: While both overrides are high, bits 7:6 are the complement of bits 5:0.
- R4: With `force_lo_n` low and `force_hi_n` high, `q` is 8'hC0 (bits 5:0 low, bits 7:6 high), and this appears before any clock edge.
- R5: With `force_hi_n` low and `force_lo_n` high, `q` is 8'h3F (bits 5:0 high, bits 7:6 low), and this appears before any clock edge.
- R6: With both overrides low, `q` is 8'h00.
- R7: A rising clock edge while either override is low leaves `q` unchanged.
- R8: Start with both overrides low. If `force_lo_n` is released first and a clock edge occurs, `q` holds 8'h3F while `force_hi_n` stays low. `q` still shows 8'h3F after `force_hi_n` is released, and toggles to 8'hC0 on the next edge.
- R9: If both overrides are released together after being held low together, `q` reads 8'hC0 and then toggles to 8'h3F on the next edge.
- R10: Start with both overrides low. If `force_hi_n` is released first, `q` shows 8'hC0. `q` still shows 8'hC0 after `force_lo_n` is released, and toggles on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock; all toggling happens on its rising edge |
| force_hi_n | input | 1 | Active-low override that drives bits 5:0 high |
| force_lo_n | input | 1 | Active-low override that drives bits 5:0 low; it wins when both are low |
| q | output | 8 | Half-rate outputs: bits 5:0 in phase, bits 7:6 inverted |

## Verification
An override and a rising clock edge can fall in the same cycle. The bench keeps the clock running throughout every override interval. It changes the override levels one nanosecond after an edge and reads the outputs before the next edge, which shows that an override acts at once. It reads the outputs again just after that edge, which shows that the edge changed nothing. The release orderings then show whether an edge taken during an override left the stored bit in the state the next toggle needs.

// File: rtl/div2_octal_driver.sv
module div2_octal_driver #(
  parameter int N_IN  = 6,
  parameter int N_INV = 2
) (
  input  logic                    clk,
  input  logic                    force_hi_n,
  input  logic                    force_lo_n,
  output logic [N_IN+N_INV-1:0]   q
);
  localparam int W = N_IN + N_INV;

  logic run_n;
  logic tog;
  logic lvl_in;
  logic lvl_inv;
  logic run_q;

  assign run_n = force_hi_n & force_lo_n;

  // override levels are reloaded on every clock edge while held
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) tog <= force_lo_n;
    else        tog <= ~tog;
  end

  assign lvl_in  = force_lo_n & (~force_hi_n | tog);
  assign lvl_inv = force_hi_n & (~force_lo_n | ~tog);

  assign q[N_IN-1:0] = {N_IN{lvl_in}};
  assign q[W-1:N_IN] = {N_INV{lvl_inv}};

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  p_half_rate_r1: assert property (@(posedge clk) disable iff (!run_n)
    run_q |=> (q == ~$past(q)));

  always @(negedge clk) begin
    p_groups_r2: assert ((q[N_IN-1:0] == {N_IN{q[0]}}) && (q[W-1:N_IN] == {N_INV{q[W-1]}}));
    if (force_hi_n && force_lo_n)
      p_complement_r3: assert (q[W-1] == ~q[0]);
    if (!force_lo_n && force_hi_n)
      p_force_low_r4: assert (q == {{N_INV{1'b1}}, {N_IN{1'b0}}});
    if (!force_hi_n && force_lo_n)
      p_force_high_r5: assert (q == {{N_INV{1'b0}}, {N_IN{1'b1}}});
    if (!force_hi_n && !force_lo_n)
      p_all_low_r6: assert (q == '0);
  end
endmodule

// File: tb/div2_octal_driver_test.sv
`timescale 1ns/100ps
module div2_octal_driver_test;
  logic clk = 1'b0;
  logic force_hi_n = 1'b0;
  logic force_lo_n = 1'b0;
  logic [7:0] q;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  div2_octal_driver uut (.clk(clk), .force_hi_n(force_hi_n), .force_lo_n(force_lo_n), .q(q));

  always #2.5 clk = ~clk;

  // {force_lo_n, force_hi_n, q before edge, q after edge}
  localparam logic [17:0] VEC [16] = '{
    {2'b00, 8'h00, 8'h00},  // R6 R7
    {2'b10, 8'h3F, 8'h3F},  // R8 clear released first
    {2'b11, 8'h3F, 8'hC0},  // R8 then toggle
    {2'b11, 8'hC0, 8'h3F},  // R1
    {2'b11, 8'h3F, 8'hC0},  // R1
    {2'b11, 8'hC0, 8'h3F},  // R1
    {2'b01, 8'hC0, 8'hC0},  // R4 R7
    {2'b11, 8'hC0, 8'h3F},  // R1
    {2'b11, 8'h3F, 8'hC0},  // R3
    {2'b10, 8'h3F, 8'h3F},  // R5 R7
    {2'b11, 8'h3F, 8'hC0},  // R1
    {2'b00, 8'h00, 8'h00},  // R6
    {2'b01, 8'hC0, 8'hC0},  // R10 preset released first
    {2'b11, 8'hC0, 8'h3F},  // R10
    {2'b00, 8'h00, 8'h00},  // R6
    {2'b11, 8'hC0, 8'h3F}   // R9 joint release
  };

  task automatic check(input logic [7:0] exp, input string req);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h at %0t", req, q, exp, $time);
    end
  endtask

  initial begin
    #1 check(8'h00, "R6 initial both low");
    @(posedge clk); #1;
    foreach (VEC[i]) begin
      {force_lo_n, force_hi_n} = VEC[i][17:16];
      #1 check(VEC[i][15:8], $sformatf("R1-set vector %0d before edge", i));
      @(posedge clk); #1;
      check(VEC[i][7:0], $sformatf("vector %0d after edge", i));
    end
    // R1 long run: alternation and R2/R3 group relation
    for (int k = 0; k < 10; k++) begin
      logic [7:0] prev;
      prev = q;
      @(posedge clk); #1;
      check(~prev, "R1 toggle run");
      check({{2{~q[0]}}, {6{q[0]}}}, "R2 R3 grouping");
    end
    // R7: several edges during clear hold
    force_lo_n = 1'b0;
    #1 check(8'hC0, "R4 immediate");
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      check(8'hC0, "R7 edge ignored");
    end
    force_lo_n = 1'b1;
    @(posedge clk); #1;
    check(8'h3F, "R1 resume after clear");
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    #2;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule